// File: doc/BRIEF.md
# Two-Byte Serial Register Slave with Outcome Code

This block lets a host reach a small set of registers over a four-wire serial link. The host frames every access as two bytes while the enable is high. The first byte carries a direction flag and a 7-bit register address. The second byte carries the write value, or clocks the read value back out. All serial inputs are brought into the system clock domain and sampled on the rising serial-clock edge. The first bit of each byte is the most significant.

The register set has three kinds of entry. A row of read-only status bytes comes from neighbouring logic. Three configuration registers drive the rest of the chip. An identification byte and an outcome register are both read-only. The outcome register records how the last completed frame ended. Writes that target read-only entries or carry values a register cannot hold are refused. Accesses to addresses outside the set are refused too. A data byte that starts before the address has been handled within a set number of system clocks marks the frame as an overrun.

Top module: `srs_spi_regslave`

## Requirements
- R1: Bit 7 of the first byte selects the direction (1 = read, 0 = write) and bits 6..0 select the register; both bytes are taken MSB first on rising serial-clock edges while the enable is high, and a frame is always sixteen edges long.
- R2: A read frame shifts the addressed register out on the data line during the eight data-byte clocks, MSB first; status bytes sit at addresses 0x00 up to NUM_STAT-1, the identification byte (default 0xA5) at 0x14.
- R3: A write of a legal value to mode (0x10), feature (0x11) or bandwidth (0x12) appears on the matching configuration output once the frame ends, and the outcome code becomes 0x00.
- R4: A write to a read-only address (status bytes, 0x13, 0x14) changes nothing and sets outcome 0x04.
- R5: An address outside the set performs no access: a write changes nothing, a read returns 0x00, and the outcome becomes 0x03.
- R6: Unsupported values are refused with outcome 0x04 and the old setting kept: mode with bit 7 or 6 set, feature with any bit outside 0x23, bandwidth codes above 0x02.
- R7: If a data-byte clock arrives within LAT system clocks of the address byte completing, the frame is an overrun: outcome 0x02, no write, and this code takes precedence over every other.
- R8: Feature bit 0 and bit 1 each give a single-cycle pulse on their own output when written as 1 and always read back as 0; feature bit 5 is stored.
- R9: Dropping the enable before the sixteenth edge discards the frame: no write, no outcome change, and the next frame starts from its address byte.
- R10: Reading 0x13 returns the outcome code of the previous completed frame, one of 0x00, 0x02, 0x03, 0x04.
- R11: After reset mode reads 0x00, feature 0x20, bandwidth 0x00, the outcome 0x00 and the data line is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sclk | input | 1 | Serial clock from host |
| spi_sdi | input | 1 | Serial data from host |
| spi_en | input | 1 | Frame enable, active high |
| stat_in | input | NUM_STAT*8 | Parallel status bytes, byte k at address k |
| spi_sdo | output | 1 | Serial read data to host |
| cfg_mode | output | 8 | Mode register value |
| cfg_feature | output | 8 | Feature register value |
| cfg_bw | output | 8 | Bandwidth register value |
| soft_rst_pulse | output | 1 | One-cycle pulse from feature bit 0 |
| hist_clr_pulse | output | 1 | One-cycle pulse from feature bit 1 |

## Verification
A wrong bit counter or address latch shows up in the very next read frame as a shifted or wrong byte on the data line. A wrong decision between legal and refused writes shows up on the configuration outputs a few system clocks after the sixteenth edge. It also shows in the outcome byte that the following frame reads back from 0x13. Overrun and abort faults show up in that same outcome byte one frame later, so every such fault becomes visible within two frames.

// File: rtl/srs_pkg.sv
package srs_pkg;
    localparam logic [7:0] ST_OK   = 8'h00;
    localparam logic [7:0] ST_OVR  = 8'h02;
    localparam logic [7:0] ST_ADDR = 8'h03;
    localparam logic [7:0] ST_DATA = 8'h04;

    localparam logic [6:0] A_MODE = 7'h10;
    localparam logic [6:0] A_FEAT = 7'h11;
    localparam logic [6:0] A_BW   = 7'h12;
    localparam logic [6:0] A_ERR  = 7'h13;
    localparam logic [6:0] A_ID   = 7'h14;

    localparam logic [7:0] MODE_RST   = 8'h00;
    localparam logic [7:0] FEAT_RST   = 8'h20;
    localparam logic [7:0] BW_RST     = 8'h00;
    localparam logic [7:0] MODE_LEGAL = 8'h3F;
    localparam logic [7:0] FEAT_LEGAL = 8'h23;
    localparam logic [7:0] FEAT_KEEP  = 8'h20;
    localparam logic [7:0] BW_MAX     = 8'h02;
    localparam int         FEAT_SRST  = 0;
    localparam int         FEAT_HCLR  = 1;

    typedef enum logic [1:0] {
        K_NONE = 2'd0,
        K_RO   = 2'd1,
        K_RW   = 2'd2
    } acc_kind_e;
endpackage

// File: rtl/srs_sync_edge.sv
module srs_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk_i,
    input  logic sdi_i,
    input  logic en_i,
    output logic rise_o,
    output logic bit_o,
    output logic en_o
);
    typedef struct packed {
        logic [STAGES-1:0] sck;
        logic [STAGES-1:0] dat;
        logic [STAGES-1:0] ena;
        logic              sck_prev;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d          = s_q;
        s_d.sck      = {s_q.sck[STAGES-2:0], sclk_i};
        s_d.dat      = {s_q.dat[STAGES-2:0], sdi_i};
        s_d.ena      = {s_q.ena[STAGES-2:0], en_i};
        s_d.sck_prev = s_q.sck[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign rise_o = s_q.sck[STAGES-1] & ~s_q.sck_prev;
    assign bit_o  = s_q.dat[STAGES-1];
    assign en_o   = s_q.ena[STAGES-1];
endmodule

// File: rtl/srs_regfile.sv
module srs_regfile
    import srs_pkg::*;
#(
    parameter int         NUM_STAT = 4,
    parameter logic [7:0] ID_VALUE = 8'hA5
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [6:0]            addr_i,
    input  logic [7:0]            wdata_i,
    input  logic                  wr_en_i,
    input  logic [7:0]            err_i,
    input  logic [NUM_STAT*8-1:0] stat_i,
    output acc_kind_e             kind_o,
    output logic                  data_ok_o,
    output logic [7:0]            rdata_o,
    output logic [7:0]            mode_o,
    output logic [7:0]            feat_o,
    output logic [7:0]            bw_o,
    output logic                  srst_o,
    output logic                  hclr_o
);
    localparam int IDX_W = (NUM_STAT > 1) ? $clog2(NUM_STAT) : 1;

    typedef struct packed {
        logic [7:0] mode;
        logic [7:0] feat;
        logic [7:0] bw;
        logic       srst;
        logic       hclr;
    } rf_t;

    rf_t r_d, r_q;
    logic [7:0] stat_arr [NUM_STAT];

    for (genvar g = 0; g < NUM_STAT; g++) begin : g_stat
        assign stat_arr[g] = stat_i[g*8 +: 8];
    end

    // decode: access kind, read value and value legality for the frame address
    always_comb begin
        kind_o    = K_NONE;
        rdata_o   = '0;
        data_ok_o = 1'b0;
        if (int'(addr_i) < NUM_STAT) begin
            kind_o  = K_RO;
            rdata_o = stat_arr[addr_i[IDX_W-1:0]];
        end else begin
            case (addr_i)
                A_MODE: begin
                    kind_o    = K_RW;
                    rdata_o   = r_q.mode;
                    data_ok_o = (wdata_i & ~MODE_LEGAL) == 8'h00;
                end
                A_FEAT: begin
                    kind_o    = K_RW;
                    rdata_o   = r_q.feat;
                    data_ok_o = (wdata_i & ~FEAT_LEGAL) == 8'h00;
                end
                A_BW: begin
                    kind_o    = K_RW;
                    rdata_o   = r_q.bw;
                    data_ok_o = wdata_i <= BW_MAX;
                end
                A_ERR: begin
                    kind_o  = K_RO;
                    rdata_o = err_i;
                end
                A_ID: begin
                    kind_o  = K_RO;
                    rdata_o = ID_VALUE;
                end
                default: kind_o = K_NONE;
            endcase
        end
    end

    always_comb begin
        r_d      = r_q;
        r_d.srst = 1'b0;
        r_d.hclr = 1'b0;
        if (wr_en_i && data_ok_o && kind_o == K_RW) begin
            case (addr_i)
                A_MODE: r_d.mode = wdata_i;
                A_FEAT: begin
                    r_d.feat = wdata_i & FEAT_KEEP;
                    r_d.srst = wdata_i[FEAT_SRST];
                    r_d.hclr = wdata_i[FEAT_HCLR];
                end
                A_BW:   r_d.bw = wdata_i;
                default: r_d = r_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.mode <= MODE_RST;
            r_q.feat <= FEAT_RST;
            r_q.bw   <= BW_RST;
            r_q.srst <= 1'b0;
            r_q.hclr <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign mode_o = r_q.mode;
    assign feat_o = r_q.feat;
    assign bw_o   = r_q.bw;
    assign srst_o = r_q.srst;
    assign hclr_o = r_q.hclr;

    assert_bw_legal_R6: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.bw <= BW_MAX)
        else $error("bandwidth register holds an undefined code");

    assert_srst_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.srst |=> !r_q.srst)
        else $error("soft reset pulse longer than one cycle");

    assert_hclr_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.hclr |=> !r_q.hclr)
        else $error("history clear pulse longer than one cycle");

    assert_cfg_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en_i |=> ($stable(r_q.mode) && $stable(r_q.feat) && $stable(r_q.bw)))
        else $error("configuration changed without a write");
endmodule

// File: rtl/srs_spi_regslave.sv
module srs_spi_regslave
    import srs_pkg::*;
#(
    parameter int         LAT      = 4,
    parameter int         NUM_STAT = 4,
    parameter logic [7:0] ID_VALUE = 8'hA5,
    parameter int         SYNC     = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  spi_sclk,
    input  logic                  spi_sdi,
    input  logic                  spi_en,
    input  logic [NUM_STAT*8-1:0] stat_in,
    output logic                  spi_sdo,
    output logic [7:0]            cfg_mode,
    output logic [7:0]            cfg_feature,
    output logic [7:0]            cfg_bw,
    output logic                  soft_rst_pulse,
    output logic                  hist_clr_pulse
);
    localparam int LW = $clog2(LAT + 1);
    localparam logic [3:0] LAST_ADDR_BIT = 4'd7;
    localparam logic [3:0] LAST_BIT      = 4'd15;

    typedef struct packed {
        logic [3:0]    cnt;
        logic [7:0]    sh;
        logic          rw;
        logic [6:0]    addr;
        logic [LW-1:0] busy;
        logic          ovr;
        logic [7:0]    osh;
        logic [7:0]    err;
    } fr_t;

    fr_t s_d, s_q;

    logic      rise_s, sdi_s, en_s;
    logic [7:0] sh_nx;
    logic [6:0] rf_addr;
    logic      ovr_now;
    logic      wr_en;
    acc_kind_e rf_kind;
    logic      rf_ok;
    logic [7:0] rf_rdata;

    srs_sync_edge #(.STAGES(SYNC)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .sclk_i (spi_sclk),
        .sdi_i  (spi_sdi),
        .en_i   (spi_en),
        .rise_o (rise_s),
        .bit_o  (sdi_s),
        .en_o   (en_s)
    );

    always_comb begin
        sh_nx   = {s_q.sh[6:0], sdi_s};
        rf_addr = (en_s && rise_s && s_q.cnt == LAST_ADDR_BIT) ? sh_nx[6:0] : s_q.addr;
    end

    srs_regfile #(.NUM_STAT(NUM_STAT), .ID_VALUE(ID_VALUE)) u_rf (
        .clk       (clk),
        .rst_n     (rst_n),
        .addr_i    (rf_addr),
        .wdata_i   (sh_nx),
        .wr_en_i   (wr_en),
        .err_i     (s_q.err),
        .stat_i    (stat_in),
        .kind_o    (rf_kind),
        .data_ok_o (rf_ok),
        .rdata_o   (rf_rdata),
        .mode_o    (cfg_mode),
        .feat_o    (cfg_feature),
        .bw_o      (cfg_bw),
        .srst_o    (soft_rst_pulse),
        .hclr_o    (hist_clr_pulse)
    );

    // frame sequencer: bit count, latency window, outcome code
    always_comb begin
        s_d     = s_q;
        wr_en   = 1'b0;
        ovr_now = s_q.ovr | (s_q.busy != '0);
        if (s_q.busy != '0) s_d.busy = s_q.busy - 1'b1;
        if (!en_s) begin
            s_d.cnt  = '0;
            s_d.ovr  = 1'b0;
            s_d.osh  = '0;
            s_d.busy = '0;
        end else if (rise_s) begin
            s_d.sh  = sh_nx;
            s_d.cnt = s_q.cnt + 4'd1;
            if (s_q.cnt == LAST_ADDR_BIT) begin
                s_d.rw   = sh_nx[7];
                s_d.addr = sh_nx[6:0];
                s_d.busy = LW'(LAT);
                s_d.ovr  = 1'b0;
                s_d.osh  = (sh_nx[7] && rf_kind != K_NONE) ? rf_rdata : 8'h00;
            end else if (s_q.cnt[3]) begin
                s_d.ovr = ovr_now;
                s_d.osh = {s_q.osh[6:0], 1'b0};
                if (s_q.cnt == LAST_BIT) begin
                    s_d.cnt = '0;
                    s_d.osh = '0;
                    s_d.ovr = 1'b0;
                    if (ovr_now)                s_d.err = ST_OVR;
                    else if (rf_kind == K_NONE) s_d.err = ST_ADDR;
                    else if (s_q.rw)            s_d.err = ST_OK;
                    else if (rf_kind != K_RW || !rf_ok) s_d.err = ST_DATA;
                    else begin
                        s_d.err = ST_OK;
                        wr_en   = 1'b1;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign spi_sdo = s_q.osh[7];

    assert_abort_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !en_s |=> (s_q.cnt == 4'd0))
        else $error("frame not discarded on enable drop");

    assert_err_code_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.err == ST_OK || s_q.err == ST_OVR || s_q.err == ST_ADDR || s_q.err == ST_DATA))
        else $error("outcome register holds an undefined code");

    assert_write_ok_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (s_q.err == ST_OK && s_q.cnt == 4'd0))
        else $error("write committed without success code");
endmodule

// File: tb/srs_spi_regslave_bench.sv
module srs_spi_regslave_bench;
    localparam int CLK_P  = 10;
    localparam int HALF   = 4;
    localparam int B_LAT  = 12;
    localparam int NSTAT  = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic spi_sclk = 1'b0, spi_sdi = 1'b0, spi_en = 1'b0;
    logic [NSTAT*8-1:0] stat_in = '0;
    logic spi_sdo, soft_rst_pulse, hist_clr_pulse;
    logic [7:0] cfg_mode, cfg_feature, cfg_bw;

    int n_cmp = 0, n_bad = 0, srst_cnt = 0, hclr_cnt = 0;
    bit done = 1'b0;
    logic [7:0] exp_v[$];
    string      exp_t[$];
    logic [7:0] got_v[$];

    always #(CLK_P/2) clk = ~clk;

    srs_spi_regslave #(.LAT(B_LAT), .NUM_STAT(NSTAT), .ID_VALUE(8'hA5), .SYNC(2)) u_srs_spi_regslave (
        .clk(clk), .rst_n(rst_n), .spi_sclk(spi_sclk), .spi_sdi(spi_sdi), .spi_en(spi_en),
        .stat_in(stat_in), .spi_sdo(spi_sdo), .cfg_mode(cfg_mode), .cfg_feature(cfg_feature),
        .cfg_bw(cfg_bw), .soft_rst_pulse(soft_rst_pulse), .hist_clr_pulse(hist_clr_pulse)
    );

    always @(posedge clk) begin
        if (soft_rst_pulse) srst_cnt <= srst_cnt + 1;
        if (hist_clr_pulse) hclr_cnt <= hclr_cnt + 1;
    end

    task automatic chk(input logic [7:0] act, input logic [7:0] expv, input string tag);
        n_cmp++;
        if (act !== expv) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, expv);
        end
    endtask

    // monitor: pairs captured read bytes with expected scoreboard entries
    initial begin
        forever begin
            @(negedge clk);
            while (got_v.size() > 0 && exp_v.size() > 0) begin
                logic [7:0] g, e;
                string t;
                g = got_v.pop_front();
                e = exp_v.pop_front();
                t = exp_t.pop_front();
                chk(g, e, t);
            end
        end
    end

    task automatic sbit(input logic b, input int lo, output logic seen);
        spi_sdi = b;
        repeat (lo) @(negedge clk);
        seen = spi_sdo;
        spi_sclk = 1'b1;
        repeat (HALF) @(negedge clk);
        spi_sclk = 1'b0;
    endtask

    task automatic xfer(input logic rd, input logic [6:0] a, input logic [7:0] d,
                        input int first_lo, output logic [7:0] rx);
        logic [7:0] ab;
        logic s;
        ab = {rd, a};
        @(negedge clk);
        spi_en = 1'b1;
        repeat (2) @(negedge clk);
        for (int i = 7; i >= 0; i--) sbit(ab[i], HALF, s);
        for (int i = 7; i >= 0; i--) begin
            sbit(d[i], (i == 7) ? first_lo : HALF, s);
            rx[i] = s;
        end
        repeat (HALF) @(negedge clk);
        spi_en = 1'b0;
        repeat (6) @(negedge clk);
    endtask

    task automatic rd_sb(input logic [6:0] a, input logic [7:0] e, input string tag);
        logic [7:0] rx;
        exp_v.push_back(e);
        exp_t.push_back(tag);
        xfer(1'b1, a, 8'h00, 20, rx);
        got_v.push_back(rx);
    endtask

    task automatic wr(input logic [6:0] a, input logic [7:0] d, input int first_lo);
        logic [7:0] rx;
        xfer(1'b0, a, d, first_lo, rx);
    endtask

    initial begin
        logic s;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(cfg_mode, 8'h00, "R11 mode reset");
        chk(cfg_feature, 8'h20, "R11 feature reset");
        chk(cfg_bw, 8'h00, "R11 bw reset");
        chk({7'd0, spi_sdo}, 8'h00, "R11 sdo idle");
        rd_sb(7'h13, 8'h00, "R11 outcome reset");

        rd_sb(7'h14, 8'hA5, "R2 id read");
        rd_sb(7'h11, 8'h20, "R2 feature read");
        stat_in = 32'h5A3C817E;
        rd_sb(7'h00, 8'h7E, "R1 status 0");
        rd_sb(7'h01, 8'h81, "R1 status 1");
        rd_sb(7'h02, 8'h3C, "R2 status 2");
        rd_sb(7'h03, 8'h5A, "R2 status 3");

        wr(7'h10, 8'h1B, 20);
        chk(cfg_mode, 8'h1B, "R3 mode write");
        rd_sb(7'h13, 8'h00, "R10 outcome ok");
        rd_sb(7'h10, 8'h1B, "R3 mode readback");

        wr(7'h14, 8'h77, 20);
        rd_sb(7'h13, 8'h04, "R4 write id outcome");
        rd_sb(7'h14, 8'hA5, "R4 id unchanged");
        wr(7'h01, 8'h00, 20);
        rd_sb(7'h13, 8'h04, "R4 write status outcome");

        wr(7'h7F, 8'h33, 20);
        rd_sb(7'h13, 8'h03, "R5 write bad address");
        rd_sb(7'h30, 8'h00, "R5 read bad address data");
        rd_sb(7'h13, 8'h03, "R5 read bad address outcome");

        wr(7'h10, 8'hC1, 20);
        chk(cfg_mode, 8'h1B, "R6 mode illegal kept");
        rd_sb(7'h13, 8'h04, "R6 mode illegal outcome");
        wr(7'h12, 8'h03, 20);
        chk(cfg_bw, 8'h00, "R6 bw code 3 kept");
        rd_sb(7'h13, 8'h04, "R6 bw illegal outcome");
        wr(7'h12, 8'h02, 20);
        chk(cfg_bw, 8'h02, "R6 bw code 2 taken");
        wr(7'h11, 8'h08, 20);
        chk(cfg_feature, 8'h20, "R6 feature illegal kept");
        rd_sb(7'h13, 8'h04, "R6 feature illegal outcome");

        wr(7'h10, 8'h05, 1);
        chk(cfg_mode, 8'h1B, "R7 overrun no write");
        rd_sb(7'h13, 8'h02, "R7 overrun outcome");
        wr(7'h7E, 8'hFF, 1);
        rd_sb(7'h13, 8'h02, "R7 overrun beats address error");

        wr(7'h11, 8'h03, 20);
        chk(srst_cnt[7:0], 8'd1, "R8 soft reset pulse count");
        chk(hclr_cnt[7:0], 8'd1, "R8 history clear pulse count");
        chk(cfg_feature, 8'h00, "R8 feature self clear");
        rd_sb(7'h11, 8'h00, "R8 feature readback");
        wr(7'h11, 8'h21, 20);
        chk(srst_cnt[7:0], 8'd2, "R8 second soft reset");
        chk(hclr_cnt[7:0], 8'd1, "R8 history clear untouched");
        chk(cfg_feature, 8'h20, "R8 bit5 stored");

        wr(7'h7F, 8'h00, 20);
        @(negedge clk);
        spi_en = 1'b1;
        repeat (2) @(negedge clk);
        for (int i = 7; i >= 0; i--) sbit(((8'h10 >> i) & 8'h01) != 8'h00, HALF, s);
        for (int i = 0; i < 3; i++) sbit(1'b1, 20, s);
        spi_en = 1'b0;
        repeat (8) @(negedge clk);
        chk(cfg_mode, 8'h1B, "R9 abort no write");
        rd_sb(7'h13, 8'h03, "R9 abort outcome unchanged");
        rd_sb(7'h10, 8'h1B, "R9 fresh frame after abort");

        repeat (10) @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule